// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Pulse Frame

This block is a small memory-mapped register frame that converts message-signalled interrupt writes into interrupt pulses. A device posts a write to the doorbell register. The low ten bits of the written data carry an absolute interrupt ID. The frame subtracts its first handled ID from that value. If the result lands inside the frame's window, the frame pulses the matching line of its output vector for exactly one clock cycle. The output vector has up to 128 lines and feeds shared peripheral interrupt inputs.

Software finds the window through a type register, which holds the first ID and the line count in packed fields. A fixed identification word and a read-as-zero identification area complete the read map. The register bus is a plain single-cycle port with these signals: address, read and write strobes, write data, an access size given in bytes, and registered read data. Any malformed access raises a one-cycle error flag. Two elaboration parameters set the window: a base offset, where the first ID is that offset plus 32, and a line count. Elaboration stops if the line count exceeds 128 or if the window would reach past ID 1020.

Top module: `msi_spi_frame`

## Requirements
- R1: After a synchronous reset, the pulse vector, the error flag and the read data are all zero.
- R2: A 4-byte read at offset 0x008 returns the first handled ID (base offset + 32) in bits [31:16] and the line count in bits [9:0], with every other bit zero.
- R3: A 4-byte read at offset 0xFCC returns 0x0510_0000: product code 0x51 in bits [27:20], and the other fields zero.
- R4: A 4-byte read at any word-aligned offset from 0xFD0 to 0xFFC returns zero and raises no error.
- R5: A write to offset 0x040 with size 2 or 4 takes ID = wdata[9:0]. When FIRST <= ID < FIRST + LINES, it pulses exactly the line ID - FIRST. Bits [31:10] of the data have no effect.
- R6: The line pulses in the cycle after the write and stays high for exactly one cycle. No line is high in a cycle that does not follow a doorbell write.
- R7: A doorbell write whose ID falls outside the window pulses no line and raises no error.
- R8: A write whose size is not 2 or 4 pulses no line and raises the error flag.
- R9: A read whose size is not 4, or whose offset is not one of those in R2 to R4 (this includes 0x040), returns zero and raises the error flag.
- R10: A write to any offset other than 0x040 changes no output except the error flag, which it raises.
- R11: The error flag and the read data follow the access by one cycle and last for one cycle. Without a read, the read data is zero. Without an access, the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 12 | Byte offset into the frame |
| reg_wen | input | 1 | Write strobe, one cycle per access |
| reg_ren | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 32 | Write data, little-endian |
| reg_size | input | 3 | Access size in bytes (2 and 4 are meaningful) |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_ren |
| irq_pulse | output | LINES | One-cycle interrupt pulses, one line per ID in the window |
| acc_err | output | 1 | One-cycle flag for a bad access |

## Verification
Directed doorbell writes are placed on the first ID of the window, on the last ID, and on the IDs just outside each end. They separate a correct rebase and bound from an off-by-one error at either edge. Further writes repeat in-window IDs with junk in the upper data bits and with both legal sizes, which exposes a decode that uses too many data bits or rejects a 2-byte write. Random traffic mixes every offset class, illegal sizes and IDs on both sides of the window. Idle cycles between accesses catch a pulse or flag that lasts longer than one cycle.

// File: rtl/msi_spi_frame.sv
module msi_spi_frame #(
  parameter int unsigned BASE_OFS = 0,
  parameter int unsigned LINES    = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [11:0]      reg_addr,
  input  logic             reg_wen,
  input  logic             reg_ren,
  input  logic [31:0]      reg_wdata,
  input  logic [2:0]       reg_size,
  output logic [31:0]      reg_rdata,
  output logic [LINES-1:0] irq_pulse,
  output logic             acc_err
);
  localparam int unsigned FIRST = BASE_OFS + 32;
  localparam logic [11:0] OFS_TYPE  = 12'h008;
  localparam logic [11:0] OFS_BELL  = 12'h040;
  localparam logic [11:0] OFS_IDENT = 12'hFCC;
  localparam logic [11:0] OFS_IDLO  = 12'hFD0;
  localparam logic [31:0] TYPE_VAL  = (32'(FIRST) << 16) | 32'(LINES);
  localparam logic [31:0] IDENT_VAL = 32'h51 << 20;

  if (LINES < 1 || LINES > 128) begin : g_bad_lines
    $error("line count out of range");
  end
  if (FIRST > 1020 - LINES) begin : g_bad_base
    $error("interrupt window passes ID 1020");
  end

  wire unused_hi = ^reg_wdata[31:10];

  wire [10:0] id     = {1'b0, reg_wdata[9:0]};
  wire [10:0] rel    = id - 11'(FIRST);
  wire        in_win = (id >= 11'(FIRST)) && (rel < 11'(LINES));
  wire        wsz_ok = (reg_size == 3'd2) || (reg_size == 3'd4);
  wire        is_bell = reg_addr == OFS_BELL;
  wire        fire   = reg_wen && is_bell && wsz_ok && in_win;
  wire        werr   = reg_wen && !(is_bell && wsz_ok);

  logic        rd_hit;
  logic [31:0] rd_val;
  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    if (reg_addr == OFS_TYPE)                            rd_val = TYPE_VAL;
    else if (reg_addr == OFS_IDENT)                      rd_val = IDENT_VAL;
    else if (reg_addr >= OFS_IDLO && reg_addr[1:0] == 2'b00) rd_val = '0;
    else                                                 rd_hit = 1'b0;
  end

  wire rd_ok = reg_ren && (reg_size == 3'd4) && rd_hit;
  wire rerr  = reg_ren && !((reg_size == 3'd4) && rd_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= '0;
      reg_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      irq_pulse <= fire ? ({{(LINES-1){1'b0}}, 1'b1} << rel) : '0;
      reg_rdata <= rd_ok ? rd_val : '0;
      acc_err   <= werr | rerr;
    end
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_pulse)); // R5
  AST_PULSE_AFTER_BELL: assert property (@(posedge clk) disable iff (rst)
    (|irq_pulse) |-> $past(reg_wen && reg_addr == OFS_BELL)); // R10
  AST_PULSE_SIZE_OK: assert property (@(posedge clk) disable iff (rst)
    (|irq_pulse) |-> $past(reg_size == 3'd2 || reg_size == 3'd4)); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wen) |-> (irq_pulse == '0)); // R6
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_ren) |-> (reg_rdata == '0)); // R11
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(reg_wen || reg_ren)); // R11
endmodule

// File: tb/sim_msi_spi_frame.sv
module sim_msi_spi_frame;
  localparam int unsigned BASE_OFS = 8;
  localparam int unsigned LINES    = 48;
  localparam int unsigned FIRST    = BASE_OFS + 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [11:0]      reg_addr = '0;
  logic             reg_wen = 1'b0;
  logic             reg_ren = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [2:0]       reg_size = '0;
  logic [31:0]      reg_rdata;
  logic [LINES-1:0] irq_pulse;
  logic             acc_err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  msi_spi_frame #(.BASE_OFS(BASE_OFS), .LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_size(reg_size),
    .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .acc_err(acc_err));

  function automatic logic [LINES-1:0] exp_pulse(logic [11:0] a, logic [31:0] d, logic [2:0] s);
    int id;
    id = int'(d[9:0]);
    if (a == 12'h040 && (s == 3'd2 || s == 3'd4) && id >= FIRST && id < FIRST + LINES)
      return {{(LINES-1){1'b0}}, 1'b1} << (id - FIRST);
    return '0;
  endfunction

  function automatic logic rd_known(logic [11:0] a);
    return a == 12'h008 || a == 12'hFCC || (a >= 12'hFD0 && a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a, logic [2:0] s);
    if (s != 3'd4) return '0;
    if (a == 12'h008) return (32'(FIRST) << 16) | 32'(LINES);
    if (a == 12'hFCC) return 32'h0510_0000;
    return '0;
  endfunction

  function automatic logic exp_err(logic w, logic [11:0] a, logic [2:0] s);
    if (w) return !(a == 12'h040 && (s == 3'd2 || s == 3'd4));
    return !(s == 3'd4 && rd_known(a));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic w, logic [11:0] a, logic [31:0] d, logic [2:0] s, string req);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_size = s;
    reg_wen = w; reg_ren = !w;
    @(negedge clk);
    reg_wen = 1'b0; reg_ren = 1'b0;
    check({req, " pulse"}, 64'(irq_pulse), 64'(w ? exp_pulse(a, d, s) : '0));
    check({req, " err"},   64'(acc_err),   64'(exp_err(w, a, s)));
    check({req, " rdata"}, 64'(reg_rdata), 64'(w ? 32'h0 : exp_rd(a, s)));
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R6 idle pulse", 64'(irq_pulse), 64'h0);
    check("R11 idle err", 64'(acc_err), 64'h0);
    check("R11 idle rdata", 64'(reg_rdata), 64'h0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset pulse", 64'(irq_pulse), 64'h0);
    check("R1 reset err", 64'(acc_err), 64'h0);
    check("R1 reset rdata", 64'(reg_rdata), 64'h0);
    rst = 1'b0;

    access(1'b0, 12'h008, '0, 3'd4, "R2 type");
    access(1'b0, 12'hFCC, '0, 3'd4, "R3 ident");
    access(1'b0, 12'hFD0, '0, 3'd4, "R4 id low");
    access(1'b0, 12'hFFC, '0, 3'd4, "R4 id high");
    access(1'b1, 12'h040, 32'(FIRST), 3'd4, "R5 first id");
    idle_check();
    access(1'b1, 12'h040, 32'(FIRST + LINES - 1), 3'd2, "R5 last id");
    access(1'b1, 12'h040, 32'hABCD_F000 | 32'(FIRST + 7), 3'd4, "R5 high bits");
    access(1'b1, 12'h040, 32'(FIRST - 1), 3'd4, "R7 below window");
    access(1'b1, 12'h040, 32'(FIRST + LINES), 3'd4, "R7 above window");
    access(1'b1, 12'h040, 32'h3FF, 3'd4, "R7 max id");
    access(1'b1, 12'h040, 32'(FIRST + 3), 3'd1, "R8 size1");
    access(1'b1, 12'h040, 32'(FIRST + 3), 3'd0, "R8 size0");
    access(1'b1, 12'h040, 32'(FIRST + 3), 3'd3, "R8 size3");
    access(1'b0, 12'h008, '0, 3'd2, "R9 read size2");
    access(1'b0, 12'h000, '0, 3'd4, "R9 read undecoded");
    access(1'b0, 12'h040, '0, 3'd4, "R9 read bell");
    access(1'b0, 12'hFD2, '0, 3'd4, "R9 read misaligned");
    access(1'b1, 12'h008, 32'(FIRST + 2), 3'd4, "R10 write type");
    access(1'b1, 12'h044, 32'(FIRST + 2), 3'd4, "R10 write near bell");
    access(1'b0, 12'h008, '0, 3'd4, "R10 type unchanged");
    idle_check();

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [2:0]  s;
      logic [31:0] d;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1, 2, 3: a = 12'h040;
        4: a = 12'h008;
        5: a = 12'hFCC;
        6: a = 12'hFD0 + 12'($urandom_range(0, 11) * 4);
        default: a = 12'($urandom_range(0, 4095));
      endcase
      s = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                      : (($urandom_range(0, 1) == 0) ? 3'd2 : 3'd4);
      d = {22'($urandom), 10'($urandom_range(FIRST - 8, FIRST + LINES + 8))};
      access($urandom_range(0, 1) == 0, a, d, s, "R5 R7 R8 R9 R10 random");
      if ($urandom_range(0, 3) == 0) idle_check();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule